// File: doc/BRIEF.md
# Dual-Channel Synthesizer Loop Controller

This block is the clocked digital core of a two-channel frequency synthesizer. For each channel it divides a shared reference tick stream down to a comparison rate. It then compares the divided reference against an already-divided feedback pulse in a phase-frequency detector, and issues source/sink commands to an external charge pump. The polarity of the pump response can be set per channel, and the pump can be forced to high impedance.

Around the two loops the block works out whether each channel is powered. It does this from a software enable bit, optionally qualified by a hardware pin. It also detects lock by measuring how long each phase error lasts. A shared output pin is steered to a general-purpose port bit, to a lock indication, or to one of the divider signals for counter testing. The current-boost request for the first channel's pump is also decoded here. All configuration arrives as static input levels, because the serial programming path is outside this block. Channel 1 uses index 0 of every two-bit vector and channel 2 uses index 1.

Top module: `twin_synth_ctrl`

## Requirements
- R1: Each channel's reference divider emits a one-cycle pulse the cycle after every R-th qualifying reference tick. R is the 12-bit divider field, and a field value of 0 means 4096.
- R2: With `cfg_pre2`=1, only every second reference tick qualifies, counting from reset or power-up, so the divide ratio becomes 2*R. With `cfg_pre2`=0, every tick qualifies.
- R3: A divided reference pulse sets a lead flag and a feedback pulse sets a lag flag. On the cycle that would leave both set, both are cleared instead. Reference and feedback pulses arriving together therefore produce no command.
- R4: With the polarity bit at 1, the lead flag drives `cp_snk` and the lag flag drives `cp_src`. With the polarity bit at 0 the two are swapped. The two outputs are never high together.
- R5: A set `cfg_tri` bit holds both pump commands of that channel low.
- R6: A channel is on when `cfg_hwpd`=0 and `cfg_swon`=1, or when `cfg_hwpd`=1, `cfg_swon`=1 and `pd_pin`=1. An off channel holds its divider, detector and lock state cleared, and it shows low pump commands and low lock.
- R7: A comparison ends on the cycle the flags clear. Its width is the number of cycles either flag was high, counting the clearing cycle. A width below `lock_win` counts as good. `lock` rises the cycle after the 16th consecutive good comparison and falls the cycle after any wider one.
- R8: With `cfg_test`=0, `port_o[2]` follows `cfg_lsel`: 00 gives `cfg_port[2]`, 01 gives channel 2 lock, 10 gives channel 1 lock, and 11 gives the OR of both locks.
- R9: With `cfg_test`=1 and `cfg_lsel`=10, `port_o[2]` carries channel 1's divided reference pulse if `cfg_pol[0]`=1, or its feedback input if `cfg_pol[0]`=0. With `cfg_lsel`=01 the same holds for channel 2 using `cfg_pol[1]`. The codes 00 and 11 behave as in R8.
- R10: `hicur1` is high when `cfg_hicur`=1 and either `cfg_hicur_pin_en`=0 or `hicur_pin`=1.
- R11: `port_o[3]` follows `cfg_port[3]`. `port_o[0]`, `port_o[1]` and `port_o[4]` follow their port bits, but read 1 (released) while those pins serve as inputs: bit 0 while `cfg_hicur_pin_en`=1, bit 1 while `cfg_hwpd[0]`=1, and bit 4 while `cfg_hwpd[1]`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference oscillator tick, one cycle per edge |
| fb_tick | input | 2 | Divided feedback pulse per channel |
| cfg_rdiv1 | input | 12 | Channel 1 reference divide field |
| cfg_rdiv2 | input | 12 | Channel 2 reference divide field |
| cfg_pre2 | input | 1 | Reference pre-divide by two enable |
| cfg_pol | input | 2 | Pump polarity per channel (1 = normal) |
| cfg_tri | input | 2 | Force pump high impedance per channel |
| cfg_test | input | 1 | Counter test enable for the shared pin |
| cfg_lsel | input | 2 | Shared pin select: bit 1 channel 1, bit 0 channel 2 |
| cfg_port | input | 5 | Open-collector port bits (1 = released) |
| cfg_hwpd | input | 2 | Hand power control to the hardware pin per channel |
| cfg_swon | input | 2 | Software power enable per channel |
| pd_pin | input | 2 | Hardware power pin level per channel |
| cfg_hicur | input | 1 | Channel 1 high pump current request |
| cfg_hicur_pin_en | input | 1 | Qualify high current with the external pin |
| hicur_pin | input | 1 | External high-current control level |
| lock_win | input | 8 | Lock window in clock cycles |
| cp_src | output | 2 | Pump source command per channel |
| cp_snk | output | 2 | Pump sink command per channel |
| lock | output | 2 | Lock indication per channel |
| ch_on | output | 2 | Qualified power state per channel |
| hicur1 | output | 1 | Channel 1 high-current select |
| port_o | output | 5 | Port pin outputs, bit 2 being the shared pin |

## Verification
The power state, the current select, the port bits and the shared-pin selection are combinational, so they are due in the same cycle as the configuration that sets them. The divided reference pulse comes one cycle after the qualifying tick, the detector flags one cycle after that pulse, and a lock change one cycle after the comparison that decides it. The bench advances its reference model on each rising edge, using the inputs held since the previous falling edge. It compares every output at the next falling edge before it drives new inputs, so each result is checked in exactly the cycle it is due. Divide ratios are also measured directly on the shared pin in test mode, as the spacing between successive pulses.

// File: rtl/twin_synth_ctrl.sv
module twin_synth_ctrl #(
  parameter int RW    = 12,
  parameter int WW    = 8,
  parameter int LOCKN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic [1:0]    fb_tick,
  input  logic [RW-1:0] cfg_rdiv1,
  input  logic [RW-1:0] cfg_rdiv2,
  input  logic          cfg_pre2,
  input  logic [1:0]    cfg_pol,
  input  logic [1:0]    cfg_tri,
  input  logic          cfg_test,
  input  logic [1:0]    cfg_lsel,
  input  logic [4:0]    cfg_port,
  input  logic [1:0]    cfg_hwpd,
  input  logic [1:0]    cfg_swon,
  input  logic [1:0]    pd_pin,
  input  logic          cfg_hicur,
  input  logic          cfg_hicur_pin_en,
  input  logic          hicur_pin,
  input  logic [WW-1:0] lock_win,
  output logic [1:0]    cp_src,
  output logic [1:0]    cp_snk,
  output logic [1:0]    lock,
  output logic [1:0]    ch_on,
  output logic          hicur1,
  output logic [4:0]    port_o
);
  localparam int GW = $clog2(LOCKN + 1);
  localparam logic [RW:0] RFULL = (RW+1)'(1) << RW;

  logic [1:0] rp_w;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [RW-1:0] rsel, cnt;
    logic [RW:0]   lim;
    logic          pre, rp, up, dn, lk;
    logic          qual, nu, nd, evt, good;
    logic [WW-1:0] wcnt;
    logic [WW:0]   wid;
    logic [GW-1:0] gcnt;

    assign ch_on[c] = cfg_swon[c] & (~cfg_hwpd[c] | pd_pin[c]);
    assign rsel = (c == 0) ? cfg_rdiv1 : cfg_rdiv2;
    assign lim  = (rsel == '0) ? RFULL : {1'b0, rsel};
    assign qual = ref_tick & (~cfg_pre2 | pre);
    assign nu   = up | rp;
    assign nd   = dn | fb_tick[c];
    assign evt  = nu & nd;
    assign wid  = {1'b0, wcnt} + (WW+1)'(up | dn);
    assign good = wid < {1'b0, lock_win};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pre <= 1'b0; cnt <= '0; rp <= 1'b0; up <= 1'b0; dn <= 1'b0;
        wcnt <= '0; gcnt <= '0; lk <= 1'b0;
      end else if (!ch_on[c]) begin
        pre <= 1'b0; cnt <= '0; rp <= 1'b0; up <= 1'b0; dn <= 1'b0;
        wcnt <= '0; gcnt <= '0; lk <= 1'b0;
      end else begin
        pre <= cfg_pre2 & (pre ^ ref_tick);
        if (qual) begin
          if ({1'b0, cnt} == lim - (RW+1)'(1)) begin
            cnt <= '0;
            rp  <= 1'b1;
          end else begin
            cnt <= cnt + RW'(1);
            rp  <= 1'b0;
          end
        end else begin
          rp <= 1'b0;
        end
        up <= nu & ~evt;
        dn <= nd & ~evt;
        if (evt) wcnt <= '0;
        else if ((up | dn) && wcnt != '1) wcnt <= wcnt + WW'(1);
        if (evt) begin
          if (good) begin
            if (gcnt != GW'(LOCKN)) gcnt <= gcnt + GW'(1);
            if (gcnt == GW'(LOCKN - 1)) lk <= 1'b1;
          end else begin
            gcnt <= '0;
            lk   <= 1'b0;
          end
        end
      end
    end

    assign rp_w[c]   = rp;
    assign cp_src[c] = ch_on[c] & ~cfg_tri[c] & (cfg_pol[c] ? dn : up);
    assign cp_snk[c] = ch_on[c] & ~cfg_tri[c] & (cfg_pol[c] ? up : dn);
    assign lock[c]   = ch_on[c] & lk;

    a_r4_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(cp_src[c] && cp_snk[c]));
    a_r5_tristate: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_tri[c] |-> !(cp_src[c] || cp_snk[c]));
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_on[c] && evt) |=> !(up || dn));
    a_r6_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_on[c] |=> (!lk && !rp && !up && !dn));
    a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_on[c] && evt && !good) |=> !lk);
  end

  logic lock_mux, pin2;

  always_comb begin
    case (cfg_lsel)
      2'b00:   lock_mux = cfg_port[2];
      2'b01:   lock_mux = lock[1];
      2'b10:   lock_mux = lock[0];
      default: lock_mux = lock[0] | lock[1];
    endcase
    if (cfg_test && cfg_lsel == 2'b10)
      pin2 = cfg_pol[0] ? rp_w[0] : fb_tick[0];
    else if (cfg_test && cfg_lsel == 2'b01)
      pin2 = cfg_pol[1] ? rp_w[1] : fb_tick[1];
    else
      pin2 = lock_mux;
  end

  assign hicur1 = cfg_hicur & (~cfg_hicur_pin_en | hicur_pin);
  assign port_o = {cfg_hwpd[1] | cfg_port[4], cfg_port[3], pin2,
                   cfg_hwpd[0] | cfg_port[1], cfg_hicur_pin_en | cfg_port[0]};

  a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hicur_pin_en && !hicur_pin) |-> !hicur1);
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hwpd[0] |-> port_o[1]);
endmodule

// File: tb/tb_twin_synth_ctrl.sv
module tb_twin_synth_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [1:0]  fb_tick = '0;
  logic [11:0] cfg_rdiv1 = 12'd5, cfg_rdiv2 = 12'd7;
  logic        cfg_pre2 = 1'b0;
  logic [1:0]  cfg_pol = 2'b11, cfg_tri = 2'b00;
  logic        cfg_test = 1'b0;
  logic [1:0]  cfg_lsel = 2'b00;
  logic [4:0]  cfg_port = 5'b10101;
  logic [1:0]  cfg_hwpd = 2'b00, cfg_swon = 2'b11, pd_pin = 2'b11;
  logic        cfg_hicur = 1'b0, cfg_hicur_pin_en = 1'b0, hicur_pin = 1'b0;
  logic [7:0]  lock_win = 8'd4;
  logic [1:0]  cp_src, cp_snk, lock, ch_on;
  logic        hicur1;
  logic [4:0]  port_o;

  twin_synth_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .cfg_rdiv1(cfg_rdiv1), .cfg_rdiv2(cfg_rdiv2), .cfg_pre2(cfg_pre2),
    .cfg_pol(cfg_pol), .cfg_tri(cfg_tri), .cfg_test(cfg_test), .cfg_lsel(cfg_lsel),
    .cfg_port(cfg_port), .cfg_hwpd(cfg_hwpd), .cfg_swon(cfg_swon), .pd_pin(pd_pin),
    .cfg_hicur(cfg_hicur), .cfg_hicur_pin_en(cfg_hicur_pin_en), .hicur_pin(hicur_pin),
    .lock_win(lock_win), .cp_src(cp_src), .cp_snk(cp_snk), .lock(lock),
    .ch_on(ch_on), .hicur1(hicur1), .port_o(port_o));

  always #10 clk = ~clk;

  int vectors = 0, fails = 0;
  int m_pre[2], m_cnt[2], m_rp[2], m_up[2], m_dn[2], m_w[2], m_g[2], m_lk[2];
  int cyc = 0, ref_per = 2, fb_per[2], fb_off[2];
  int rnd = 0, last_rise = -1, per_meas = -1, prev_pin = 0;

  function automatic int pw(int c);
    return (cfg_swon[c] && (!cfg_hwpd[c] || pd_pin[c])) ? 1 : 0;
  endfunction

  task automatic mclear(int c);
    m_pre[c] = 0; m_cnt[c] = 0; m_rp[c] = 0; m_up[c] = 0; m_dn[c] = 0;
    m_w[c] = 0; m_g[c] = 0; m_lk[c] = 0;
  endtask

  task automatic mstep(int c);
    int r, lim, qual, nu, nd, evt, wid;
    if (!pw(c)) begin mclear(c); return; end
    r    = (c == 0) ? int'(cfg_rdiv1) : int'(cfg_rdiv2);
    lim  = (r == 0) ? 4096 : r;
    qual = (ref_tick && (!cfg_pre2 || m_pre[c])) ? 1 : 0;
    nu   = (m_up[c] || m_rp[c]) ? 1 : 0;
    nd   = (m_dn[c] || fb_tick[c]) ? 1 : 0;
    evt  = nu & nd;
    wid  = m_w[c] + ((m_up[c] || m_dn[c]) ? 1 : 0);
    if (evt) begin
      if (wid < int'(lock_win)) begin
        if (m_g[c] == 15) m_lk[c] = 1;
        if (m_g[c] < 16) m_g[c]++;
      end else begin
        m_g[c] = 0; m_lk[c] = 0;
      end
    end
    if (evt) m_w[c] = 0;
    else if ((m_up[c] || m_dn[c]) && m_w[c] < 255) m_w[c]++;
    m_up[c] = nu & ~evt & 1;
    m_dn[c] = nd & ~evt & 1;
    m_pre[c] = cfg_pre2 ? (m_pre[c] ^ int'(ref_tick)) : 0;
    if (qual) begin
      if (m_cnt[c] == lim - 1) begin m_cnt[c] = 0; m_rp[c] = 1; end
      else begin m_cnt[c] = (m_cnt[c] + 1) % 4096; m_rp[c] = 0; end
    end else m_rp[c] = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin mclear(0); mclear(1); end
    else begin mstep(0); mstep(1); end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic compare();
    int on, esrc, esnk, l0, l1, p2;
    string tag;
    for (int c = 0; c < 2; c++) begin
      on   = pw(c);
      esrc = (on && !cfg_tri[c]) ? (cfg_pol[c] ? m_dn[c] : m_up[c]) : 0;
      esnk = (on && !cfg_tri[c]) ? (cfg_pol[c] ? m_up[c] : m_dn[c]) : 0;
      tag  = !on ? "R6" : (cfg_tri[c] ? "R5" : "R3 R4");
      chk(tag, int'(cp_src[c]), esrc);
      chk(tag, int'(cp_snk[c]), esnk);
      chk("R7", int'(lock[c]), on ? m_lk[c] : 0);
      chk("R6", int'(ch_on[c]), on);
    end
    l0 = pw(0) ? m_lk[0] : 0;
    l1 = pw(1) ? m_lk[1] : 0;
    if (cfg_test && cfg_lsel == 2'b10) p2 = cfg_pol[0] ? m_rp[0] : int'(fb_tick[0]);
    else if (cfg_test && cfg_lsel == 2'b01) p2 = cfg_pol[1] ? m_rp[1] : int'(fb_tick[1]);
    else if (cfg_lsel == 2'b00) p2 = int'(cfg_port[2]);
    else if (cfg_lsel == 2'b01) p2 = l1;
    else if (cfg_lsel == 2'b10) p2 = l0;
    else p2 = l0 | l1;
    chk(cfg_test ? "R9" : "R8", int'(port_o[2]), p2);
    chk("R10", int'(hicur1), (cfg_hicur && (!cfg_hicur_pin_en || hicur_pin)) ? 1 : 0);
    chk("R11", int'({port_o[4], port_o[3], port_o[1], port_o[0]}),
        int'({cfg_hwpd[1] | cfg_port[4], cfg_port[3],
              cfg_hwpd[0] | cfg_port[1], cfg_hicur_pin_en | cfg_port[0]}));
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    if (port_o[2] && !prev_pin) begin
      if (last_rise >= 0) per_meas = cyc - last_rise;
      last_rise = cyc;
    end
    prev_pin = int'(port_o[2]);
    cyc++;
    if (rnd) begin
      ref_tick = ($urandom_range(0, 3) != 0);
      fb_tick  = {($urandom_range(0, 12) == 0), ($urandom_range(0, 8) == 0)};
    end else begin
      ref_tick = ((cyc % ref_per) == 0);
      for (int c = 0; c < 2; c++)
        fb_tick[c] = (fb_per[c] > 0) && (((cyc + fb_off[c]) % fb_per[c]) == 0);
    end
  endtask

  task automatic run(int n);
    repeat (n) step();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R1-R11 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    fb_per[0] = 10; fb_per[1] = 14; fb_off[0] = 0; fb_off[1] = 0;
    run(4);                                   // reset state, all requirements
    rst_n = 1'b1;
    // R7: sweep phase offsets with matched rates, lock and unlock
    for (int o = 0; o < 10; o++) begin
      fb_off[0] = o; fb_off[1] = o + 3; run(300);
    end
    // R3 R4: rate mismatch under both polarities
    for (int p = 0; p < 4; p++) begin
      cfg_pol = 2'(p); fb_per[0] = 9; fb_per[1] = 15; run(500);
    end
    cfg_pol = 2'b11; fb_per[0] = 10; fb_per[1] = 14;
    // R5: forced tristate
    for (int t = 0; t < 4; t++) begin cfg_tri = 2'(t); run(250); end
    cfg_tri = 2'b00;
    // R2 via the loops
    cfg_pre2 = 1'b1; fb_per[0] = 20; fb_per[1] = 28; run(1000);
    // R1 R2 R9: measured divide ratios on the shared pin
    cfg_test = 1'b1; cfg_lsel = 2'b10; cfg_pol = 2'b11; ref_per = 1;
    cfg_pre2 = 1'b1; cfg_rdiv1 = 12'd5;
    last_rise = -1; per_meas = -1; run(60);
    chk("R2", per_meas, 10);
    cfg_pre2 = 1'b0; cfg_lsel = 2'b01; cfg_rdiv2 = 12'd7;
    last_rise = -1; per_meas = -1; run(60);
    chk("R1", per_meas, 7);
    cfg_lsel = 2'b10; cfg_rdiv1 = 12'd0;
    last_rise = -1; per_meas = -1; run(4096 * 3 + 20);
    chk("R1", per_meas, 4096);
    cfg_rdiv1 = 12'd5; cfg_pol = 2'b00; run(100);
    cfg_lsel = 2'b01; run(100);
    cfg_pol = 2'b11; ref_per = 2; fb_per[0] = 10; fb_per[1] = 14;
    // R8 R9: every shared pin selection
    for (int m = 0; m < 32; m++) begin
      cfg_test = m[4]; cfg_lsel = 2'(m >> 2); cfg_pol = 2'(m); cfg_port[2] = m[0];
      run(60);
    end
    cfg_test = 1'b0; cfg_pol = 2'b11;
    // R6: power qualification
    for (int k = 0; k < 64; k++) begin
      cfg_hwpd = 2'(k); cfg_swon = 2'(k >> 2); pd_pin = 2'(k >> 4); run(40);
    end
    cfg_hwpd = 2'b00; cfg_swon = 2'b11;
    // R10 R11: current select and port release
    for (int k = 0; k < 8; k++) begin
      cfg_hicur = k[0]; cfg_hicur_pin_en = k[1]; hicur_pin = k[2]; run(5);
    end
    for (int k = 0; k < 16; k++) begin
      cfg_port = 5'(k * 7); cfg_hwpd = 2'(k); cfg_hicur_pin_en = k[2]; run(5);
    end
    // random segments over the whole configuration space
    for (int s = 0; s < 200; s++) begin
      rnd = s[0];
      cfg_rdiv1 = 12'($urandom_range(1, 12)); cfg_rdiv2 = 12'($urandom_range(1, 12));
      cfg_pre2 = 1'($urandom); cfg_pol = 2'($urandom); cfg_tri = 2'($urandom_range(0, 5) == 0);
      cfg_test = 1'($urandom); cfg_lsel = 2'($urandom); cfg_port = 5'($urandom);
      cfg_hwpd = 2'($urandom); cfg_swon = 2'($urandom_range(1, 3)); pd_pin = 2'($urandom_range(1, 3));
      cfg_hicur = 1'($urandom); cfg_hicur_pin_en = 1'($urandom); hicur_pin = 1'($urandom);
      lock_win = 8'($urandom_range(1, 30));
      ref_per = $urandom_range(1, 3);
      fb_per[0] = $urandom_range(3, 30); fb_per[1] = $urandom_range(3, 30);
      fb_off[0] = $urandom_range(0, 9); fb_off[1] = $urandom_range(0, 9);
      run(200);
    end
    summary();
    $finish;
  end
endmodule